// File: doc/BRIEF.md
# SPI Master Phase Sequencer

This block runs a single SPI master transaction as a chain of optional phases: a command byte, an address of one to four bytes, a run of single-wire dummy cycles, and write and read data phases. A 4-bit order code picks one of ten fixed data-phase orderings. The command and address phases, when enabled, always come first. The transaction settings are latched on a start pulse, so the inputs may change while the transfer runs.

A separate timing block owns SCLK and chip-select timing. It offers a `tick` for each SCLK slot. The sequencer answers with `sclk_beat` on each slot it actually uses, so the timing block toggles SCLK only on beats. Write bytes come from a TX FIFO through a pop handshake, and read bytes go to an RX FIFO through a push handshake. When the FIFO side is not ready, the sequencer holds the bus still instead of losing data.

Each phase drives one, two or four lanes. On every beat, the sequencer presents the next group of bits of the current byte and shifts in the bits it receives.

Top module: `spi_phase_seq`

## Requirements
- R1: Data phases follow the order code. 0 = simultaneous write/read, 1 = write, 2 = read, 3 = write then read, 4 = read then write, 5 = write, dummy, read, 6 = read, dummy, write, 7 = no data, 8 = dummy then write, 9 = dummy then read. When enabled, the command phase comes first, then the address phase, then the data phases.
- R2: A code of 10 to 15, or code 0, 2, 6 or 7 with the command phase disabled, is rejected. The cycle after start, `err` and `done` pulse together, and there is no beat and no busy.
- R3: The command phase sends the 8-bit command MSB first. It uses one lane, or the data lane width when `cmd_wide` is set.
- R4: The address phase sends `addr_len`+1 bytes (0 = 1 byte up to 3 = 4 bytes), most significant byte first. It uses one lane, or the data lane width when `addr_wide` is set.
- R5: The dummy phase lasts `dummy_cnt`+1 beats, and no lane is driven during it.
- R6: A write phase moves `wr_cnt`+1 bytes and a read phase moves `rd_cnt`+1 bytes. The simultaneous mode moves `wr_cnt`+1 bytes in each direction.
- R7: The data width is 4 lanes when `quad_en` is set, otherwise 2 lanes when `dual_en` is set, otherwise 1 lane. Each beat carries the most significant remaining bits, with the highest bit on the highest lane. Single-lane reads take lane 1, or lane 0 when `three_wire` is set. The simultaneous mode always uses one lane out (lane 0) and one lane in.
- R8: When `lsb_first` is set, write and read data bytes are bit-reversed. Command and address bytes are never reversed.
- R9: A write phase does not start a byte while the TX FIFO is empty. A read byte's last beat waits while the RX FIFO is full. `tx_pop` happens only with `tx_avail`, and `rx_push` only with `rx_room`.
- R10: `busy` rises the cycle after an accepted start. `done` is a one-cycle pulse that coincides with `busy` falling after the last beat.
- R11: A beat happens only in a cycle where `tick` is high.
- R12: `lane_oe` enables the lanes in use during command, address and write phases. It enables lane 0 only in simultaneous mode, and no lane during dummy, read or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| start | input | 1 | begin a transaction (ignored while busy) |
| mode | input | 4 | data-phase order code |
| cmd_en | input | 1 | enable command phase |
| cmd_wide | input | 1 | command on data lane width |
| cmd_byte | input | 8 | command value |
| addr_en | input | 1 | enable address phase |
| addr_wide | input | 1 | address on data lane width |
| addr_len | input | 2 | address bytes minus one |
| addr | input | 32 | address value |
| dummy_cnt | input | 4 | dummy beats minus one |
| wr_cnt | input | CNT_W | write bytes minus one |
| rd_cnt | input | CNT_W | read bytes minus one |
| lsb_first | input | 1 | reverse data bit order |
| dual_en | input | 1 | two-lane data |
| quad_en | input | 1 | four-lane data |
| three_wire | input | 1 | single-lane reads on lane 0 |
| tick | input | 1 | SCLK slot offered by timing block |
| lane_in | input | 4 | sampled lane values |
| lane_out | output | 4 | lane drive values |
| lane_oe | output | 4 | lane output enables |
| sclk_beat | output | 1 | slot used this cycle |
| tx_avail | input | 1 | TX FIFO not empty |
| tx_byte | input | 8 | TX FIFO head |
| tx_pop | output | 1 | take TX head |
| rx_room | input | 1 | RX FIFO not full |
| rx_push | output | 1 | write RX byte |
| rx_byte | output | 8 | received byte |
| busy | output | 1 | transaction running |
| done | output | 1 | end-of-transfer pulse |
| err | output | 1 | rejected-start pulse |

## Verification
The bench builds the block with 16-bit byte counts and the default four-byte address. This keeps every transfer to a few dozen beats while still covering the full address length. At these sizes, each order family can be reached in a short run: wide commands, three-byte addresses, dummy runs, and both FIFO stall points. The bench also covers a one-in-three tick rate, so gating is exercised alongside beat counting. Long counts are left to the counter logic, which is identical at any width.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CMD   = 3'd1,
        PH_ADDR  = 3'd2,
        PH_DUMMY = 3'd3,
        PH_WR    = 3'd4,
        PH_RD    = 3'd5,
        PH_WRRD  = 3'd6,
        PH_END   = 3'd7
    } phase_e;

    localparam int BYTE_W = 8;

    function automatic logic [BYTE_W-1:0] bit_rev8(input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/spi_seq_order.sv
module spi_seq_order
    import spi_seq_pkg::*;
(
    input  logic [3:0] mode,
    input  logic [1:0] idx,
    input  logic       cmd_on,
    output phase_e     ph,
    output logic       legal
);
    phase_e a, b, c;

    always_comb begin
        a = PH_END; b = PH_END; c = PH_END;
        case (mode)
            4'd0: a = PH_WRRD;
            4'd1: a = PH_WR;
            4'd2: a = PH_RD;
            4'd3: begin a = PH_WR;    b = PH_RD; end
            4'd4: begin a = PH_RD;    b = PH_WR; end
            4'd5: begin a = PH_WR;    b = PH_DUMMY; c = PH_RD; end
            4'd6: begin a = PH_RD;    b = PH_DUMMY; c = PH_WR; end
            4'd8: begin a = PH_DUMMY; b = PH_WR; end
            4'd9: begin a = PH_DUMMY; b = PH_RD; end
            default: ;
        endcase
        case (idx)
            2'd0:    ph = a;
            2'd1:    ph = b;
            2'd2:    ph = c;
            default: ph = PH_END;
        endcase
        legal = (mode <= 4'd9) &&
                (cmd_on || !(mode == 4'd0 || mode == 4'd2 || mode == 4'd6 || mode == 4'd7));
    end
endmodule

// File: rtl/spi_seq_lanes.sv
module spi_seq_lanes
    import spi_seq_pkg::*;
(
    input  logic [BYTE_W-1:0] sh,
    input  logic [1:0]        lw,
    input  logic              in_on_lane0,
    input  logic [3:0]        din,
    output logic [3:0]        dout,
    output logic [BYTE_W-1:0] sh_next
);
    always_comb begin
        case (lw)
            2'd0: begin
                dout    = {3'b000, sh[7]};
                sh_next = {sh[6:0], in_on_lane0 ? din[0] : din[1]};
            end
            2'd1: begin
                dout    = {2'b00, sh[7:6]};
                sh_next = {sh[5:0], din[1:0]};
            end
            default: begin
                dout    = sh[7:4];
                sh_next = {sh[3:0], din};
            end
        endcase
    end
endmodule

// File: rtl/spi_phase_seq.sv
module spi_phase_seq
    import spi_seq_pkg::*;
#(
    parameter  int CNT_W      = 24,
    parameter  int ADDR_BYTES = 4,
    localparam int ADDR_W     = BYTE_W * ADDR_BYTES,
    localparam int ALEN_W     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic              cmd_en,
    input  logic              cmd_wide,
    input  logic [7:0]        cmd_byte,
    input  logic              addr_en,
    input  logic              addr_wide,
    input  logic [ALEN_W-1:0] addr_len,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        dummy_cnt,
    input  logic [CNT_W-1:0]  wr_cnt,
    input  logic [CNT_W-1:0]  rd_cnt,
    input  logic              lsb_first,
    input  logic              dual_en,
    input  logic              quad_en,
    input  logic              three_wire,
    input  logic              tick,
    input  logic [3:0]        lane_in,
    output logic [3:0]        lane_out,
    output logic [3:0]        lane_oe,
    output logic              sclk_beat,
    input  logic              tx_avail,
    input  logic [7:0]        tx_byte,
    output logic              tx_pop,
    input  logic              rx_room,
    output logic              rx_push,
    output logic [7:0]        rx_byte,
    output logic              busy,
    output logic              done,
    output logic              err
);
    typedef struct packed {
        logic [3:0]        mode;
        logic              cmd_en;
        logic              cmd_wide;
        logic [7:0]        cmd_byte;
        logic              addr_en;
        logic              addr_wide;
        logic [ALEN_W-1:0] addr_len;
        logic [ADDR_W-1:0] addr;
        logic [3:0]        dummy_cnt;
        logic [CNT_W-1:0]  wr_cnt;
        logic [CNT_W-1:0]  rd_cnt;
        logic              lsb;
        logic [1:0]        dw;
        logic              three_wire;
    } cfg_t;

    typedef struct packed {
        phase_e            ph;
        logic [1:0]        didx;
        logic              loaded;
        logic [BYTE_W-1:0] sh;
        logic [2:0]        beats;
        logic [CNT_W-1:0]  left;
        logic [1:0]        lw;
        logic              done;
        logic              err;
        cfg_t              cfg;
    } st_t;

    function automatic logic [BYTE_W-1:0] addr_byte(input logic [ADDR_W-1:0] a,
                                                    input logic [CNT_W-1:0]  i);
        logic [ADDR_W-1:0] t;
        t = a >> (i * BYTE_W);
        return t[BYTE_W-1:0];
    endfunction

    // Sets up the per-phase fields on entry to phase p.
    function automatic st_t enter(input st_t s, input phase_e p, input cfg_t c);
        st_t r;
        r        = s;
        r.ph     = p;
        r.loaded = 1'b1;
        r.left   = '0;
        r.lw     = 2'd0;
        case (p)
            PH_CMD: begin
                r.lw = c.cmd_wide ? c.dw : 2'd0;
                r.sh = c.cmd_byte;
            end
            PH_ADDR: begin
                r.lw   = c.addr_wide ? c.dw : 2'd0;
                r.left = CNT_W'(c.addr_len);
                r.sh   = addr_byte(c.addr, CNT_W'(c.addr_len));
            end
            PH_DUMMY: r.left = CNT_W'(c.dummy_cnt);
            PH_WR: begin
                r.lw     = c.dw;
                r.left   = c.wr_cnt;
                r.loaded = 1'b0;
            end
            PH_RD: begin
                r.lw   = c.dw;
                r.left = c.rd_cnt;
            end
            PH_WRRD: begin
                r.left   = c.wr_cnt;
                r.loaded = 1'b0;
            end
            default: ;
        endcase
        r.beats = 3'd7 >> r.lw;
        return r;
    endfunction

    st_t               q, n;
    cfg_t              cfg_in, c_run;
    phase_e            seq_ph, tgt;
    logic              legal, idle, advance, last, wr_like, rd_like;
    logic [1:0]        idx_cur;
    logic [3:0]        lane_raw;
    logic [BYTE_W-1:0] sh_next;

    assign cfg_in = '{mode: mode, cmd_en: cmd_en, cmd_wide: cmd_wide, cmd_byte: cmd_byte,
                      addr_en: addr_en, addr_wide: addr_wide, addr_len: addr_len, addr: addr,
                      dummy_cnt: dummy_cnt, wr_cnt: wr_cnt, rd_cnt: rd_cnt, lsb: lsb_first,
                      dw: quad_en ? 2'd2 : (dual_en ? 2'd1 : 2'd0), three_wire: three_wire};

    assign idle    = (q.ph == PH_IDLE);
    assign c_run   = idle ? cfg_in : q.cfg;
    assign idx_cur = idle ? 2'd0 : q.didx;
    assign last    = (q.beats == 3'd0);
    assign wr_like = (q.ph == PH_WR) || (q.ph == PH_WRRD);
    assign rd_like = (q.ph == PH_RD) || (q.ph == PH_WRRD);

    spi_seq_order u_order (
        .mode   (c_run.mode),
        .idx    (idx_cur),
        .cmd_on (c_run.cmd_en),
        .ph     (seq_ph),
        .legal  (legal)
    );

    spi_seq_lanes u_lanes (
        .sh          (q.sh),
        .lw          (q.lw),
        .in_on_lane0 (q.cfg.three_wire),
        .din         (lane_in),
        .dout        (lane_raw),
        .sh_next     (sh_next)
    );

    always_comb begin
        n         = q;
        n.done    = 1'b0;
        n.err     = 1'b0;
        tx_pop    = 1'b0;
        rx_push   = 1'b0;
        sclk_beat = 1'b0;
        advance   = 1'b0;
        tgt       = PH_END;
        case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    if (!legal) begin
                        n.done = 1'b1;
                        n.err  = 1'b1;
                    end else begin
                        n.cfg   = cfg_in;
                        advance = 1'b1;
                    end
                end
            end
            PH_DUMMY: begin
                if (tick) begin
                    sclk_beat = 1'b1;
                    if (q.left == '0) advance = 1'b1;
                    else              n.left = q.left - 1'b1;
                end
            end
            PH_CMD, PH_ADDR, PH_WR, PH_RD, PH_WRRD: begin
                if (wr_like && !q.loaded) begin
                    if (tx_avail) begin
                        tx_pop   = 1'b1;
                        n.sh     = q.cfg.lsb ? bit_rev8(tx_byte) : tx_byte;
                        n.loaded = 1'b1;
                    end
                end else if (tick && !(rd_like && last && !rx_room)) begin
                    sclk_beat = 1'b1;
                    n.sh      = sh_next;
                    rx_push   = rd_like && last;
                    if (!last) begin
                        n.beats = q.beats - 1'b1;
                    end else if (q.left == '0) begin
                        advance = 1'b1;
                    end else begin
                        n.left  = q.left - 1'b1;
                        n.beats = 3'd7 >> q.lw;
                        if (q.ph == PH_ADDR) n.sh = addr_byte(q.cfg.addr, q.left - 1'b1);
                        if (wr_like) n.loaded = 1'b0;
                    end
                end
            end
            default: n.ph = PH_IDLE;
        endcase

        if (advance) begin
            n.didx = idx_cur;
            if (idle && c_run.cmd_en) begin
                tgt = PH_CMD;
            end else if ((idle || q.ph == PH_CMD) && c_run.addr_en) begin
                tgt = PH_ADDR;
            end else begin
                tgt    = seq_ph;
                n.didx = idx_cur + 2'd1;
            end
            if (tgt == PH_END) begin
                n.ph   = PH_IDLE;
                n.done = 1'b1;
            end else begin
                n = enter(n, tgt, c_run);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        case (q.ph)
            PH_CMD, PH_ADDR, PH_WR:
                lane_oe = (q.lw == 2'd0) ? 4'b0001 : ((q.lw == 2'd1) ? 4'b0011 : 4'b1111);
            PH_WRRD: lane_oe = 4'b0001;
            default: lane_oe = 4'b0000;
        endcase
    end

    assign lane_out = lane_raw & lane_oe;
    assign rx_byte  = q.cfg.lsb ? bit_rev8(sh_next) : sh_next;
    assign busy     = !idle;
    assign done     = q.done;
    assign err      = q.err;
endmodule

// File: rtl/spi_phase_seq_chk.sv
module spi_phase_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [3:0] mode,
    input logic       tick,
    input logic       sclk_beat,
    input logic       tx_avail,
    input logic       tx_pop,
    input logic       rx_room,
    input logic       rx_push,
    input logic [3:0] lane_oe,
    input logic       busy,
    input logic       done,
    input logic       err
);
    assert_beat_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_beat |-> (tick && busy));

    assert_pop_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> tx_avail);

    assert_push_needs_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> (rx_room && sclk_beat));

    assert_reserved_rejected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode >= 4'd10) |=> (err && done && !busy));

    assert_err_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !busy));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_write_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 4'd1) |=> busy);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lane_oe == 4'b0000 && !sclk_beat));
endmodule

bind spi_phase_seq spi_phase_seq_chk u_chk (.*);

// File: tb/spi_phase_seq_bench.sv
module spi_phase_seq_bench;
    localparam int CW = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, start, cmd_en, cmd_wide, addr_en, addr_wide;
    logic [3:0]    mode, dummy_cnt, lane_in, lane_out, lane_oe;
    logic [7:0]    cmd_byte, tx_byte, rx_byte;
    logic [1:0]    addr_len;
    logic [31:0]   addr;
    logic [CW-1:0] wr_cnt, rd_cnt;
    logic          lsb_first, dual_en, quad_en, three_wire, tick, sclk_beat;
    logic          tx_avail, tx_pop, rx_room, rx_push, busy, done, err;

    spi_phase_seq #(.CNT_W(CW)) u_spi_phase_seq (.*);

    logic [7:0] tx_mem [0:15];
    logic [3:0] in_mem [0:63];
    logic [3:0] log_out [0:63];
    logic [3:0] log_oe [0:63];
    logic [7:0] rx_got [0:15];
    int tx_n, tx_rd, beat_n, rx_n, done_n, err_n;
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    logic clr, tx_en, tick_all;

    assign tx_avail = tx_en && (tx_rd < tx_n);
    assign tx_byte  = tx_mem[tx_rd[3:0]];
    assign lane_in  = in_mem[beat_n[5:0]];
    assign tick     = tick_all || (cyc % 3 == 0);

    always @(negedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (clr) begin
            beat_n <= 0; tx_rd <= 0; rx_n <= 0; done_n <= 0; err_n <= 0;
        end else begin
            if (sclk_beat) begin
                log_out[beat_n[5:0]] <= lane_out;
                log_oe[beat_n[5:0]]  <= lane_oe;
                beat_n <= beat_n + 1;
            end
            if (tx_pop) tx_rd <= tx_rd + 1;
            if (rx_push) begin
                rx_got[rx_n[3:0]] <= rx_byte;
                rx_n <= rx_n + 1;
            end
            if (done) done_n <= done_n + 1;
            if (err)  err_n  <= err_n + 1;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0h exp %0h", what, act, exp);
        end
    endtask

    function automatic int get_byte(input int st, input int w);
        int v = 0;
        for (int k = 0; k < 8 / w; k++)
            v = (v << w) | (int'(log_out[st + k]) & ((1 << w) - 1));
        return v & 8'hFF;
    endfunction

    // lane_sel: 0 = lane0, 1 = lane1, 2 = lane0 with the inverse on lane1
    task automatic put_in(input int st, input int w, input logic [7:0] b, input int lane_sel);
        for (int k = 0; k < 8 / w; k++) begin
            int bits = (int'(b) >> (8 - w * (k + 1))) & ((1 << w) - 1);
            if (w > 1)              in_mem[st + k] = 4'(bits);
            else if (lane_sel == 1) in_mem[st + k] = {2'b00, bits[0], 1'b0};
            else if (lane_sel == 2) in_mem[st + k] = {2'b00, ~bits[0], bits[0]};
            else                    in_mem[st + k] = {3'b000, bits[0]};
        end
    endtask

    task automatic prep();
        @(negedge clk);
        clr = 1'b1; start = 1'b0; mode = 4'd1;
        cmd_en = 1'b0; cmd_wide = 1'b0; cmd_byte = 8'h00;
        addr_en = 1'b0; addr_wide = 1'b0; addr_len = 2'd0; addr = 32'h0;
        dummy_cnt = 4'd0; wr_cnt = '0; rd_cnt = '0;
        lsb_first = 1'b0; dual_en = 1'b0; quad_en = 1'b0; three_wire = 1'b0;
        tx_n = 0; tx_en = 1'b1; rx_room = 1'b1; tick_all = 1'b1;
        for (int i = 0; i < 64; i++) in_mem[i] = 4'h0;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic run(input bit legal, output int cycles);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (legal) chk("R10 busy the cycle after start", int'(busy), 1);
        else       chk("R2 rejected start leaves busy low", int'(busy), 0);
        cycles = 1;
        while (!done && cycles < 3000) begin
            @(negedge clk);
            cycles++;
        end
        chk("R10 done pulse seen", int'(done), 1);
        chk("R10 busy falls with done", int'(busy), 0);
        @(negedge clk);
        chk("R10 done lasts one cycle", int'(done), 0);
    endtask

    task automatic t_reset();
        chk("R10 reset busy low", int'(busy), 0);
        chk("R10 reset done low", int'(done), 0);
        chk("R12 reset no lane enabled", int'(lane_oe), 0);
        chk("R9 reset no pop", int'(tx_pop), 0);
    endtask

    task automatic t_cmd_addr_write();
        int cy;
        prep();
        mode = 4'd1; cmd_en = 1'b1; cmd_byte = 8'hA5;
        addr_en = 1'b1; addr_len = 2'd2; addr = 32'h0012_3456;
        wr_cnt = 16'd1; tx_mem[0] = 8'h3C; tx_mem[1] = 8'hC3; tx_n = 2;
        run(1'b1, cy);
        chk("R6 beats for cmd+3 addr+2 write", beat_n, 48);
        chk("R3 command byte MSB first", get_byte(0, 1), 8'hA5);
        chk("R4 address byte 2 first", get_byte(8, 1), 8'h12);
        chk("R4 address byte 1", get_byte(16, 1), 8'h34);
        chk("R4 address byte 0 last", get_byte(24, 1), 8'h56);
        chk("R6 write byte 0", get_byte(32, 1), 8'h3C);
        chk("R6 write byte 1", get_byte(40, 1), 8'hC3);
        chk("R6 two bytes popped", tx_rd, 2);
        chk("R12 single lane during command", int'(log_oe[0]), 1);
        chk("R2 no error on legal start", err_n, 0);
    endtask

    task automatic t_quad_read();
        int cy;
        prep();
        mode = 4'd2; cmd_en = 1'b1; cmd_wide = 1'b1; quad_en = 1'b1; dual_en = 1'b1;
        cmd_byte = 8'h9B; rd_cnt = 16'd2;
        put_in(2, 4, 8'h1F, 0); put_in(4, 4, 8'hE2, 0); put_in(6, 4, 8'h47, 0);
        run(1'b1, cy);
        chk("R7 quad cmd+3 read beats", beat_n, 8);
        chk("R3 wide command on four lanes", get_byte(0, 4), 8'h9B);
        chk("R12 four lanes enabled for wide command", int'(log_oe[0]), 4'hF);
        chk("R12 no lane enabled during read", int'(log_oe[2]), 0);
        chk("R6 three bytes read", rx_n, 3);
        chk("R7 quad read byte 0", int'(rx_got[0]), 8'h1F);
        chk("R7 quad read byte 2", int'(rx_got[2]), 8'h47);
    endtask

    task automatic t_dual_lsb_dummy();
        int cy;
        prep();
        mode = 4'd8; cmd_en = 1'b1; cmd_byte = 8'hC0; dual_en = 1'b1; lsb_first = 1'b1;
        dummy_cnt = 4'd3; wr_cnt = 16'd0; tx_mem[0] = 8'h1E; tx_n = 1;
        run(1'b1, cy);
        chk("R5 cmd+4 dummy+dual byte beats", beat_n, 16);
        chk("R8 command not reversed", get_byte(0, 1), 8'hC0);
        chk("R5 no lane driven in dummy", int'(log_oe[11]), 0);
        chk("R12 two lanes during dual write", int'(log_oe[12]), 4'h3);
        chk("R8 write byte reversed on dual lanes", get_byte(12, 2), 8'h78);
    endtask

    task automatic t_simultaneous();
        int cy;
        prep();
        mode = 4'd0; cmd_en = 1'b1; cmd_byte = 8'h3A; dual_en = 1'b1; wr_cnt = 16'd1;
        tx_mem[0] = 8'h96; tx_mem[1] = 8'h69; tx_n = 2;
        put_in(8, 1, 8'h5A, 1); put_in(16, 1, 8'hC3, 1);
        run(1'b1, cy);
        chk("R6 simultaneous beat count", beat_n, 24);
        chk("R12 lane 0 only in simultaneous", int'(log_oe[8]), 1);
        chk("R7 simultaneous write on one lane", get_byte(8, 1), 8'h96);
        chk("R6 simultaneous bytes received", rx_n, 2);
        chk("R7 simultaneous read from lane 1", int'(rx_got[0]), 8'h5A);
        chk("R7 simultaneous read byte 1", int'(rx_got[1]), 8'hC3);
    endtask

    task automatic t_three_wire();
        int cy;
        prep();
        mode = 4'd9; three_wire = 1'b1; dummy_cnt = 4'd0; rd_cnt = 16'd0;
        put_in(1, 1, 8'hB4, 2);
        run(1'b1, cy);
        chk("R5 one dummy beat plus read", beat_n, 9);
        chk("R7 three-wire read from lane 0", int'(rx_got[0]), 8'hB4);
        chk("R12 three-wire read lane released", int'(log_oe[1]), 0);
    endtask

    task automatic t_illegal();
        int cy;
        prep();
        mode = 4'd12; cmd_en = 1'b1;
        run(1'b0, cy);
        chk("R2 reserved code raises err", err_n, 1);
        chk("R2 reserved code no beats", beat_n, 0);
        prep();
        mode = 4'd2; cmd_en = 1'b0;
        run(1'b0, cy);
        chk("R2 read-only without command raises err", err_n, 1);
        chk("R2 read-only without command no beats", beat_n, 0);
    endtask

    task automatic t_stall();
        int cy;
        prep();
        mode = 4'd3; wr_cnt = 16'd0; rd_cnt = 16'd0; tx_en = 1'b0; rx_room = 1'b0;
        tx_mem[0] = 8'h55; tx_n = 1; put_in(8, 1, 8'hE7, 1);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (20) @(negedge clk);
        chk("R9 no beat with TX empty", beat_n, 0);
        chk("R9 no pop with TX empty", tx_rd, 0);
        chk("R9 still busy while stalled", int'(busy), 1);
        tx_en = 1'b1;
        repeat (30) @(negedge clk);
        chk("R9 read halts before last beat", beat_n, 15);
        chk("R9 nothing pushed while RX full", rx_n, 0);
        rx_room = 1'b1;
        cy = 0;
        while (!done && cy < 100) begin
            @(negedge clk);
            cy++;
        end
        chk("R10 stalled transfer completes", int'(done), 1);
        @(negedge clk);
        chk("R1 write then read beat total", beat_n, 16);
        chk("R1 write byte first", get_byte(0, 1), 8'h55);
        chk("R1 read byte second", int'(rx_got[0]), 8'hE7);
    endtask

    task automatic t_order_slow_tick();
        int cy;
        prep();
        mode = 4'd6; cmd_en = 1'b1; cmd_byte = 8'h11; dummy_cnt = 4'd1;
        tx_mem[0] = 8'h6C; tx_n = 1; tick_all = 1'b0;
        put_in(8, 1, 8'h2D, 1);
        run(1'b1, cy);
        chk("R1 read, dummy, write beat total", beat_n, 26);
        chk("R1 read phase after command", int'(rx_got[0]), 8'h2D);
        chk("R1 dummy between read and write", int'(log_oe[17]), 0);
        chk("R1 write phase last", get_byte(18, 1), 8'h6C);
        chk("R11 slow tick stretches transfer", int'(cy >= 70), 1);
    endtask

    initial begin
        rst_n = 1'b0; clr = 1'b1; start = 1'b0; mode = 4'd1;
        cmd_en = 1'b0; cmd_wide = 1'b0; cmd_byte = 8'h00;
        addr_en = 1'b0; addr_wide = 1'b0; addr_len = 2'd0; addr = 32'h0;
        dummy_cnt = 4'd0; wr_cnt = '0; rd_cnt = '0;
        lsb_first = 1'b0; dual_en = 1'b0; quad_en = 1'b0; three_wire = 1'b0;
        tx_n = 0; tx_en = 1'b0; rx_room = 1'b1; tick_all = 1'b1;
        for (int i = 0; i < 64; i++) in_mem[i] = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmd_addr_write();
        t_quad_read();
        t_dual_lsb_dummy();
        t_simultaneous();
        t_three_wire();
        t_illegal();
        t_stall();
        t_order_slow_tick();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL R10 watchdog: got hang exp done");
        $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
        $finish;
    end
endmodule